// File: doc/BRIEF.md
# Translation Base Register Selector

This block stores the two 64-bit table base registers of a stage-one address translation unit. One register covers the bottom of the virtual address space and the other covers the top. Software writes and reads both registers through a plain register port. For each lookup request carrying a 64-bit virtual address, the block decides which register the table walk starts from, using only the bits above the implemented address width. Those bits must all be zero or all be one. Any other pattern is reported as a translation fault.

The response arrives one cycle after the request is accepted and holds everything the walker needs to start:
- the table base address;
- the active address space identifier (ASID);
- a flag naming the range that was chosen;
- an alignment error flag for the selected base.

A configuration pin chooses which register supplies the ASID. A second pin puts the block in 8-bit ASID mode, in which the upper ASID bits read as zero.

Requests and responses use a valid/ready handshake. A request is taken on a cycle where `req_valid` and `req_ready` are both high. The response register releases its content on a cycle where `rsp_valid` and `rsp_ready` are both high. While `rsp_valid` is high and `rsp_ready` is low, the response holds unchanged and `req_ready` stays low. The register port and the configuration pins have no handshake.

Top module: `tbs_selector`

## Requirements
- R1: If `req_va[63:48]` is all zeros, the response has `rsp_hi`=0 and `rsp_fault`=0. `rsp_base` equals bits [47:0] of the low register (address 0), with bit 0 forced to zero.
- R2: If `req_va[63:48]` is all ones, the response has `rsp_hi`=1 and `rsp_fault`=0. `rsp_base` comes from bits [47:0] of the high register (address 1), with bit 0 forced to zero.
- R3: If `req_va[63:48]` mixes zeros and ones, the response has `rsp_fault`=1, and `rsp_base`, `rsp_asid`, `rsp_hi` and `rsp_misalign` are all zero.
- R4: For a request that does not fault, `rsp_asid` is bits [63:48] of the low register when `cfg_asid_hi`=0. It is bits [63:48] of the high register when `cfg_asid_hi`=1. The choice does not depend on which range was selected.
- R5: When `cfg_asid8`=1, `rsp_asid[15:8]` and `reg_rdata[63:56]` read as zero.
- R6: `rsp_misalign` is 1 exactly when a bit of `rsp_base` at a position from 1 up to E-1 is set. Here E is the larger of `cfg_align_log2` and 6. Bit 0 is never checked.
- R7: A register write takes effect at the next clock edge. A request accepted in the same cycle as the write uses the old register content.
- R8: After reset, both registers read zero, `rsp_valid` is 0 and `req_ready` is 1.
- R9: A request accepted on one edge gives `rsp_valid`=1 after that edge. While the response is stalled, all response outputs hold, `req_ready` is 0 and no new request is taken.
- R10: `reg_rdata` shows the register chosen by `reg_addr` (0 = low, 1 = high) combinationally, subject to the masking of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 low range, 1 high range |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data of the selected register |
| cfg_asid_hi | input | 1 | ASID taken from the high register when 1 |
| cfg_asid8 | input | 1 | 8-bit ASID mode |
| cfg_align_log2 | input | 6 | Log2 of the table alignment in bytes |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_va | input | 64 | Virtual address to classify |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response ready |
| rsp_hi | output | 1 | High range selected |
| rsp_fault | output | 1 | Upper address bits not uniform |
| rsp_misalign | output | 1 | Selected base violates alignment |
| rsp_base | output | 48 | Selected table base address |
| rsp_asid | output | 16 | Active ASID |

## Verification
The assertions check on every cycle:
- the handshake rules: stall hold, ready blocking, and a response after each accepted request;
- the range class that follows from each accepted address, and the clean zero outputs of a fault;
- the zeroed ASID byte in read data during 8-bit mode;
- the always-checked low base bits against the misalignment flag.

Only the bench scenarios can show value-level results:
- the exact base and ASID values;
- the full alignment threshold across every setting;
- the old-value rule for a write in the same cycle as a request;
- the reset contents.

// File: rtl/tbs_pkg.sv
package tbs_pkg;
  typedef enum logic [1:0] {
    RNG_LO  = 2'd0,
    RNG_HI  = 2'd1,
    RNG_BAD = 2'd2
  } range_e;
endpackage

// File: rtl/tbs_regfile.sv
module tbs_regfile #(
  parameter int DW          = 64,
  parameter int ASID_W      = 16,
  parameter int ASID_NARROW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  input  logic          asid8,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] lo_q,
  output logic [DW-1:0] hi_q
);
  localparam int ZW = ASID_W - ASID_NARROW;

  logic [DW-1:0] store_q [2];

  for (genvar g = 0; g < 2; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         store_q[g] <= '0;
      else if (we && (addr == 1'(g)))     store_q[g] <= wdata;
    end
  end

  assign lo_q = store_q[0];
  assign hi_q = store_q[1];

  always_comb begin
    rdata = store_q[addr];
    if (asid8) rdata[DW-1 -: ZW] = '0;
  end
endmodule

// File: rtl/tbs_range_decode.sv
module tbs_range_decode #(
  parameter int VA_W   = 64,
  parameter int IMPL_W = 48
) (
  input  logic [VA_W-IMPL_W-1:0] va_top,
  output tbs_pkg::range_e        rng
);
  always_comb begin
    if (va_top == '0)       rng = tbs_pkg::RNG_LO;
    else if (&va_top)       rng = tbs_pkg::RNG_HI;
    else                    rng = tbs_pkg::RNG_BAD;
  end
endmodule

// File: rtl/tbs_align_check.sv
module tbs_align_check #(
  parameter int BW        = 48,
  parameter int ALW       = 6,
  parameter int MIN_ALIGN = 6
) (
  input  logic [BW-1:0]  base,
  input  logic [ALW-1:0] align_log2,
  output logic           misalign
);
  localparam logic [ALW-1:0] MIN_V = ALW'(MIN_ALIGN);

  logic [ALW-1:0] eff;

  always_comb begin
    eff      = (align_log2 < MIN_V) ? MIN_V : align_log2;
    misalign = 1'b0;
    for (int i = 1; i < BW; i++) begin
      if ((i < int'(eff)) && base[i]) misalign = 1'b1;
    end
  end
endmodule

// File: rtl/tbs_selector.sv
module tbs_selector #(
  parameter int VA_W        = 64,
  parameter int IMPL_W      = 48,
  parameter int ASID_W      = 16,
  parameter int ASID_NARROW = 8,
  parameter int ALW         = 6,
  parameter int MIN_ALIGN   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic [VA_W-1:0]   reg_wdata,
  output logic [VA_W-1:0]   reg_rdata,
  input  logic              cfg_asid_hi,
  input  logic              cfg_asid8,
  input  logic [ALW-1:0]    cfg_align_log2,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hi,
  output logic              rsp_fault,
  output logic              rsp_misalign,
  output logic [VA_W-ASID_W-1:0] rsp_base,
  output logic [ASID_W-1:0] rsp_asid
);
  localparam int BW = VA_W - ASID_W;
  localparam int ZW = ASID_W - ASID_NARROW;

  logic [VA_W-1:0] lo_q, hi_q, walk_reg, asid_reg;
  tbs_pkg::range_e rng;
  logic [BW-1:0]   nxt_base;
  logic [ASID_W-1:0] nxt_asid;
  logic            nxt_mis, accept;

  tbs_regfile #(.DW(VA_W), .ASID_W(ASID_W), .ASID_NARROW(ASID_NARROW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .asid8(cfg_asid8), .rdata(reg_rdata), .lo_q(lo_q), .hi_q(hi_q)
  );

  tbs_range_decode #(.VA_W(VA_W), .IMPL_W(IMPL_W)) u_dec (
    .va_top(req_va[VA_W-1:IMPL_W]), .rng(rng)
  );

  assign walk_reg = (rng == tbs_pkg::RNG_HI) ? hi_q : lo_q;
  assign asid_reg = cfg_asid_hi ? hi_q : lo_q;
  assign nxt_base = walk_reg[BW-1:0] & ~BW'(1);

  always_comb begin
    nxt_asid = asid_reg[VA_W-1 -: ASID_W];
    if (cfg_asid8) nxt_asid[ASID_W-1 -: ZW] = '0;
  end

  tbs_align_check #(.BW(BW), .ALW(ALW), .MIN_ALIGN(MIN_ALIGN)) u_align (
    .base(nxt_base), .align_log2(cfg_align_log2), .misalign(nxt_mis)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_hi       <= 1'b0;
      rsp_fault    <= 1'b0;
      rsp_misalign <= 1'b0;
      rsp_base     <= '0;
      rsp_asid     <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      if (rng == tbs_pkg::RNG_BAD) begin
        rsp_hi       <= 1'b0;
        rsp_fault    <= 1'b1;
        rsp_misalign <= 1'b0;
        rsp_base     <= '0;
        rsp_asid     <= '0;
      end else begin
        rsp_hi       <= (rng == tbs_pkg::RNG_HI);
        rsp_fault    <= 1'b0;
        rsp_misalign <= nxt_mis;
        rsp_base     <= nxt_base;
        rsp_asid     <= nxt_asid;
      end
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tbs_selector_chk.sv
module tbs_selector_chk #(
  parameter int VA_W        = 64,
  parameter int IMPL_W      = 48,
  parameter int ASID_W      = 16,
  parameter int ASID_NARROW = 8,
  parameter int MIN_ALIGN   = 6
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [VA_W-1:0]         reg_rdata,
  input logic                    cfg_asid8,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic [VA_W-1:0]         req_va,
  input logic                    rsp_valid,
  input logic                    rsp_ready,
  input logic                    rsp_hi,
  input logic                    rsp_fault,
  input logic                    rsp_misalign,
  input logic [VA_W-ASID_W-1:0]  rsp_base,
  input logic [ASID_W-1:0]       rsp_asid
);
  localparam int ZW = ASID_W - ASID_NARROW;

  p_lo_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_va[VA_W-1:IMPL_W] == '0)) |=> (!rsp_fault && !rsp_hi));

  p_hi_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (&req_va[VA_W-1:IMPL_W])) |=> (!rsp_fault && rsp_hi));

  p_mixed_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_va[VA_W-1:IMPL_W] != '0) && !(&req_va[VA_W-1:IMPL_W]))
      |=> rsp_fault);

  p_fault_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_base == '0 && rsp_asid == '0 && !rsp_hi && !rsp_misalign));

  p_rdata_narrow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_asid8 |-> (reg_rdata[VA_W-1 -: ZW] == '0));

  p_low_bits_mis_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_base[MIN_ALIGN-1:1] != '0)) |-> rsp_misalign);

  p_accept_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  p_stall_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_base) && $stable(rsp_asid)
      && $stable(rsp_hi) && $stable(rsp_fault) && $stable(rsp_misalign)));
endmodule

bind tbs_selector tbs_selector_chk #(
  .VA_W(VA_W), .IMPL_W(IMPL_W), .ASID_W(ASID_W), .ASID_NARROW(ASID_NARROW), .MIN_ALIGN(MIN_ALIGN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata), .cfg_asid8(cfg_asid8),
  .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hi(rsp_hi), .rsp_fault(rsp_fault),
  .rsp_misalign(rsp_misalign), .rsp_base(rsp_base), .rsp_asid(rsp_asid)
);

// File: tb/test_tbs_selector.sv
`timescale 1ns/1ps
module test_tbs_selector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_addr = 1'b0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic        cfg_asid_hi = 1'b0, cfg_asid8 = 1'b0;
  logic [5:0]  cfg_align_log2 = '0;
  logic        req_valid = 1'b0, req_ready;
  logic [63:0] req_va = '0;
  logic        rsp_valid, rsp_ready = 1'b1;
  logic        rsp_hi, rsp_fault, rsp_misalign;
  logic [47:0] rsp_base;
  logic [15:0] rsp_asid;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [63:0] m_lo = '0, m_hi = '0;
  logic        e_hi, e_fault, e_mis;
  logic [47:0] e_base;
  logic [15:0] e_asid;

  always #4 clk = ~clk;

  tbs_selector i_tbs_selector (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cfg_asid_hi(cfg_asid_hi), .cfg_asid8(cfg_asid8),
    .cfg_align_log2(cfg_align_log2), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hi(rsp_hi),
    .rsp_fault(rsp_fault), .rsp_misalign(rsp_misalign), .rsp_base(rsp_base), .rsp_asid(rsp_asid)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [63:0] va);
    logic [63:0] src;
    int eff;
    e_fault = !((va[63:48] == 16'h0000) || (va[63:48] == 16'hFFFF));
    e_hi = 0; e_mis = 0; e_base = '0; e_asid = '0;
    if (!e_fault) begin
      e_hi   = (va[63:48] == 16'hFFFF);
      src    = e_hi ? m_hi : m_lo;
      e_base = {src[47:1], 1'b0};
      src    = cfg_asid_hi ? m_hi : m_lo;
      e_asid = cfg_asid8 ? {8'h00, src[55:48]} : src[63:48];
      eff    = (cfg_align_log2 < 6) ? 6 : int'(cfg_align_log2);
      for (int i = 1; i < 48; i++) if (i < eff && e_base[i]) e_mis = 1;
    end
  endfunction

  task automatic check_rsp(input string tag);
    chk({tag, " valid"}, 64'(rsp_valid), 64'd1);
    chk({tag, " fault"}, 64'(rsp_fault), 64'(e_fault));
    chk({tag, " hi"}, 64'(rsp_hi), 64'(e_hi));
    chk({tag, " base"}, 64'(rsp_base), 64'(e_base));
    chk({tag, " asid"}, 64'(rsp_asid), 64'(e_asid));
    chk({tag, " misalign"}, 64'(rsp_misalign), 64'(e_mis));
  endtask

  task automatic do_req(input logic [63:0] va, input string tag);
    @(negedge clk);
    req_valid = 1; req_va = va; rsp_ready = 1;
    model(va);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    check_rsp(tag);
  endtask

  task automatic wr(input logic a, input logic [63:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 0;
    if (a) m_hi = d; else m_lo = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] tops [34];
    logic [47:0] lows [3];
    logic [47:0] h_base;
    logic [15:0] h_asid;
    logic        h_hi;
    tops[0] = 16'h0000; tops[1] = 16'hFFFF;
    for (int k = 0; k < 16; k++) begin
      tops[2+k]  = 16'(1) << k;
      tops[18+k] = ~(16'(1) << k);
    end
    lows[0] = 48'h0; lows[1] = 48'hFFFF_FFFF_FFFF; lows[2] = 48'h8000_0000_0000;

    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R8 req_ready", 64'(req_ready), 64'd1);
    reg_addr = 0; #1 chk("R8 low reg", reg_rdata, 64'd0);
    reg_addr = 1; #1 chk("R8 high reg", reg_rdata, 64'd0);
    rst_n = 1;

    // R10 / R5 readback
    wr(0, 64'hA5C3_0000_1234_5000);
    wr(1, 64'h5A3C_FFFF_8765_4000);
    @(negedge clk);
    reg_addr = 0; #1 chk("R10 low readback", reg_rdata, m_lo);
    reg_addr = 1; #1 chk("R10 high readback", reg_rdata, m_hi);
    cfg_asid8 = 1;
    #1 chk("R5 narrow readback", reg_rdata, {8'h00, m_hi[55:0]});
    cfg_asid8 = 0;

    // R1 R2 R3 R4 R5 sweep over upper-bit patterns and ASID settings
    for (int s = 0; s < 4; s++) begin
      cfg_asid_hi = s[0]; cfg_asid8 = s[1];
      for (int t = 0; t < 34; t++)
        for (int l = 0; l < 3; l++)
          do_req({tops[t], lows[l]}, "R1/R2/R3/R4/R5 sweep");
    end
    do_req(64'h0000_FFFF_FFFF_FFFF, "R1 top of low range");
    do_req(64'hFFFF_0000_0000_0000, "R2 bottom of high range");
    do_req(64'h0001_0000_0000_0000, "R3 just above low range");
    do_req(64'hFFFE_FFFF_FFFF_FFFF, "R3 just below high range");

    // R6 alignment sweep: single base bit against every alignment setting
    cfg_asid_hi = 0; cfg_asid8 = 0;
    for (int p = 0; p < 48; p++) begin
      wr(0, {16'h00C7, 48'(1) << p});
      for (int a = 0; a < 49; a++) begin
        cfg_align_log2 = 6'(a);
        do_req(64'h0, "R6 alignment");
      end
    end
    cfg_align_log2 = 0;

    // R7 same-cycle write uses old value
    wr(0, 64'h1111_0000_0000_1000);
    @(negedge clk);
    reg_we = 1; reg_addr = 0; reg_wdata = 64'h2222_0000_0000_2000;
    req_valid = 1; req_va = 64'h0;
    model(64'h0);
    @(posedge clk);
    @(negedge clk);
    reg_we = 0; req_valid = 0;
    check_rsp("R7 old value");
    m_lo = 64'h2222_0000_0000_2000;
    do_req(64'h0, "R7 new value");

    // R9 back-pressure
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_va = 64'hFFFF_0000_0000_0040;
    model(req_va);
    h_base = e_base; h_asid = e_asid; h_hi = e_hi;
    @(posedge clk);
    @(negedge clk);
    req_va = 64'h0000_0000_0000_0040;
    chk("R9 stall ready low", 64'(req_ready), 64'd0);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R9 hold valid", 64'(rsp_valid), 64'd1);
      chk("R9 hold base", 64'(rsp_base), 64'(h_base));
      chk("R9 hold asid", 64'(rsp_asid), 64'(h_asid));
      chk("R9 hold hi", 64'(rsp_hi), 64'(h_hi));
    end
    rsp_ready = 1;
    model(req_va);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    check_rsp("R9 pending request after release");
    @(negedge clk);
    chk("R9 drains", 64'(rsp_valid), 64'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule